// File: doc/BRIEF.md
# SDRAM Bank State Legality Checker

This block sits passively on the command bus of a single-data-rate SDRAM and never drives it. On every rising clock edge it decodes the command lines. It keeps one state machine per bank and a shared timer for commands that involve the whole device. It reports any command that the current bank state forbids, and any command that comes too early for one of the device timing limits.

A violation produces a single-cycle pulse on `err_pulse` one clock after the offending edge. The pulse carries a reason code and the number of the bank held responsible. A command that is flagged is treated as never issued, so no bank and no timer changes because of it. Row and column values have no effect on legality. For that reason only the address line that selects auto-precharge, or all banks for a precharge, is observed.

All timing limits are parameters counted in clock cycles. The burst length is also a parameter: a burst occupies `BURST_LEN` edges starting at its command edge.

Top module: `sdram_cmd_guard`

## Requirements
- R1: After synchronous reset, `err_pulse` is low, and every bank is idle, so one activate to each bank spaced `T_RRD` apart raises no error.
- R2: A command is decoded from {ras_n,cas_n,we_n}: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, others are no-ops. A cycle with cs_n high is ignored. A cycle is also ignored when cke was low at the previous edge. A refresh with cke low is a self-refresh entry and is judged like a refresh.
- R3: A mode set or refresh issued while any bank is not idle gives code 1 (illegal state) and names the lowest-numbered bank that is not idle.
- R4: An activate to a bank that has an open row gives code 1 for that bank.
- R5: A read or write less than `T_RCD` cycles after the activate of its bank gives code 2. At exactly `T_RCD` it is accepted.
- R6: A precharge to an open bank less than `T_RAS` cycles after its activate gives code 3.
- R7: An activate, read or write to a bank less than `T_RP` cycles after its precharge gives code 4. At exactly `T_RP` an activate is accepted.
- R8: An accepted activate followed by another activate less than `T_RRD` cycles later gives code 5 for the second bank.
- R9: Any command other than a no-op within `T_RC` cycles of a refresh gives code 6. Within `T_MRD` cycles of a mode set it gives code 7. In both cases the reported bank is the bank address on the bus.
- R10: While a bank runs a burst with auto-precharge (address line high on the read or write), any read, write, activate or precharge to it gives code 1. The bank is idle `BURST_LEN + T_RP` cycles after an auto-precharge read.
- R11: A read or write to a bank that is in a burst is accepted and starts a new burst. A precharge during a read burst, once `T_RAS` is met, is accepted and starts the `T_RP` wait.
- R12: The error is a one-cycle pulse one clock after the offending edge. A flagged command changes no bank state and no timer.
- R13: A precharge with the address line high applies to all banks. If several banks object, the lowest-numbered one is reported.
- R14: For `T_DPL` cycles after a write burst ends, a precharge to that bank gives code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable line of the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command line |
| cas_n | input | 1 | Column strobe command line |
| we_n | input | 1 | Write enable command line |
| ba | input | BA_W | Bank address |
| addr_ap | input | 1 | Address line carrying auto-precharge / all-banks select |
| err_pulse | output | 1 | One-cycle violation flag |
| err_code | output | 3 | Reason: 1 state, 2 tRCD, 3 tRAS, 4 tRP, 5 tRRD, 6 tRC, 7 tMRD |
| err_bank | output | BA_W | Bank held responsible |

## Verification
A bank whose state machine has drifted is invisible until the next command to that bank. That command then shows a false pulse or a missing one, exactly one cycle after its edge. A counter that is off by one shows only at the boundary edge of its window. The bench therefore places each timed command at limit minus one and at the limit itself. A rejected command that still changed state would be revealed by the command that follows it, which the bench checks each time.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

    typedef enum logic [2:0] {
        C_NOP, C_MRS, C_REF, C_PRE, C_ACT, C_WR, C_RD
    } cmd_t;

    typedef enum logic [3:0] {
        B_IDLE, B_ACTIVATING, B_ACTIVE, B_READ, B_WRITE,
        B_READ_AP, B_WRITE_AP, B_PRECHARGING, B_WR_RECOV
    } bank_st_t;

    typedef enum logic [2:0] {
        E_NONE  = 3'd0,
        E_STATE = 3'd1,
        E_RCD   = 3'd2,
        E_RAS   = 3'd3,
        E_RP    = 3'd4,
        E_RRD   = 3'd5,
        E_RC    = 3'd6,
        E_MRD   = 3'd7
    } err_t;

    typedef enum logic [1:0] {G_FREE, G_REFRESH, G_MODESET} glob_st_t;

    function automatic cmd_t decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        cmd_t c;
        c = C_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b000:  c = C_MRS;
                3'b001:  c = C_REF;
                3'b010:  c = C_PRE;
                3'b011:  c = C_ACT;
                3'b100:  c = C_WR;
                3'b101:  c = C_RD;
                default: c = C_NOP;
            endcase
        end
        return c;
    endfunction

    // State a timed bank state falls into once its wait has run out.
    function automatic bank_st_t expire(input bank_st_t s);
        bank_st_t n;
        case (s)
            B_ACTIVATING:          n = B_ACTIVE;
            B_READ:                n = B_ACTIVE;
            B_WRITE:               n = B_WR_RECOV;
            B_WR_RECOV:            n = B_ACTIVE;
            B_READ_AP, B_WRITE_AP: n = B_PRECHARGING;
            B_PRECHARGING:         n = B_IDLE;
            default:               n = s;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sdg_bank.sv
module sdg_bank
    import sdg_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 7,
    parameter int T_RP      = 3,
    parameter int BURST_LEN = 4,
    parameter int T_DPL     = 2
) (
    input  logic clk,
    input  logic rst,
    input  cmd_t op,
    input  logic hit,
    input  logic ap,
    input  logic rrd_busy,
    input  logic commit,
    output err_t err,
    output logic idle_now
);
    localparam logic [CNT_W-1:0] L_RCD  = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] L_RAS  = CNT_W'(T_RAS - 1);
    localparam logic [CNT_W-1:0] L_RP   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] L_BL   = CNT_W'(BURST_LEN - 1);
    localparam logic [CNT_W-1:0] L_WAP  = CNT_W'(BURST_LEN - 1 + T_DPL);
    localparam logic [CNT_W-1:0] L_DPL  = CNT_W'(T_DPL - 1);

    bank_st_t         st, eff, nxt_st;
    logic [CNT_W-1:0] cnt, ras_left, nxt_cnt;
    logic             fresh;

    function automatic logic [CNT_W-1:0] entry_load(input bank_st_t s);
        logic [CNT_W-1:0] v;
        case (s)
            B_WR_RECOV:    v = L_DPL;
            B_PRECHARGING: v = L_RP;
            default:       v = '0;
        endcase
        return v;
    endfunction

    // Fold an expiring wait into the state seen by this edge's command.
    always_comb begin
        eff   = st;
        fresh = 1'b0;
        if (cnt == '0) begin
            eff   = expire(st);
            fresh = (eff != st);
        end
    end

    assign idle_now = (eff == B_IDLE);

    always_comb begin
        err = E_NONE;
        if (hit) begin
            case (op)
                C_ACT: begin
                    if (eff == B_IDLE)             err = rrd_busy ? E_RRD : E_NONE;
                    else if (eff == B_PRECHARGING) err = E_RP;
                    else                           err = E_STATE;
                end
                C_RD, C_WR: begin
                    case (eff)
                        B_ACTIVE, B_READ, B_WRITE, B_WR_RECOV: err = E_NONE;
                        B_ACTIVATING:  err = E_RCD;
                        B_PRECHARGING: err = E_RP;
                        default:       err = E_STATE;
                    endcase
                end
                C_PRE: begin
                    case (eff)
                        B_IDLE, B_PRECHARGING:     err = E_NONE;
                        B_ACTIVE, B_READ, B_WRITE: err = (ras_left != '0) ? E_RAS : E_NONE;
                        default:                   err = E_STATE;
                    endcase
                end
                default: err = E_NONE;
            endcase
        end
    end

    always_comb begin
        nxt_st  = eff;
        nxt_cnt = fresh ? entry_load(eff) : ((cnt != '0) ? cnt - 1'b1 : '0);
        if (hit && commit) begin
            case (op)
                C_ACT: begin
                    nxt_st  = B_ACTIVATING;
                    nxt_cnt = L_RCD;
                end
                C_RD: begin
                    nxt_st  = ap ? B_READ_AP : B_READ;
                    nxt_cnt = L_BL;
                end
                C_WR: begin
                    nxt_st  = ap ? B_WRITE_AP : B_WRITE;
                    nxt_cnt = ap ? L_WAP : L_BL;
                end
                C_PRE: begin
                    if (eff != B_IDLE && eff != B_PRECHARGING) begin
                        nxt_st  = B_PRECHARGING;
                        nxt_cnt = L_RP;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= B_IDLE;
            cnt      <= '0;
            ras_left <= '0;
        end else begin
            st  <= nxt_st;
            cnt <= nxt_cnt;
            if (hit && commit && op == C_ACT) ras_left <= L_RAS;
            else if (ras_left != '0)          ras_left <= ras_left - 1'b1;
        end
    end

    // R6: a bank only starts precharging out of an open row once tRAS ran out
    p_ras_met_r6: assert property (@(posedge clk) disable iff (rst)
        (st == B_PRECHARGING &&
         $past(st) inside {B_ACTIVATING, B_ACTIVE, B_READ, B_WRITE})
        |-> $past(ras_left) == '0);

    // R5: a burst never starts while the activation wait is still running
    p_rcd_met_r5: assert property (@(posedge clk) disable iff (rst)
        (st inside {B_READ, B_WRITE, B_READ_AP, B_WRITE_AP} &&
         $past(st) == B_ACTIVATING)
        |-> $past(cnt) == '0);

    // R10: an auto-precharge read burst cannot be disturbed
    p_ap_locked_r10: assert property (@(posedge clk) disable iff (rst)
        (st == B_READ_AP && cnt != '0) |=> st == B_READ_AP);

endmodule

// File: rtl/sdg_global.sv
module sdg_global
    import sdg_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int T_RC  = 8,
    parameter int T_MRD = 2,
    parameter int T_RRD = 2
) (
    input  logic clk,
    input  logic rst,
    input  cmd_t op,
    input  logic all_idle,
    input  logic act_done,
    output err_t g_err,
    output logic rrd_busy
);
    localparam logic [CNT_W-1:0] L_RC  = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0] L_MRD = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] L_RRD = CNT_W'(T_RRD - 1);

    glob_st_t         g_st;
    logic [CNT_W-1:0] g_cnt, rrd_cnt;
    logic             busy_now;

    assign busy_now = (g_st != G_FREE) && (g_cnt != '0);
    assign rrd_busy = (rrd_cnt != '0);

    always_comb begin
        g_err = E_NONE;
        if (busy_now && op != C_NOP)
            g_err = (g_st == G_REFRESH) ? E_RC : E_MRD;
        else if ((op == C_MRS || op == C_REF) && !all_idle)
            g_err = E_STATE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_st    <= G_FREE;
            g_cnt   <= '0;
            rrd_cnt <= '0;
        end else begin
            if (g_err == E_NONE && op == C_REF) begin
                g_st  <= G_REFRESH;
                g_cnt <= L_RC;
            end else if (g_err == E_NONE && op == C_MRS) begin
                g_st  <= G_MODESET;
                g_cnt <= L_MRD;
            end else if (busy_now) begin
                g_cnt <= g_cnt - 1'b1;
            end else begin
                g_st <= G_FREE;
            end
            if (act_done)           rrd_cnt <= L_RRD;
            else if (rrd_cnt != '0) rrd_cnt <= rrd_cnt - 1'b1;
        end
    end

    // R3: the device-wide waits are only entered from an all-idle device
    p_enter_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (g_st != G_FREE && $past(g_st) == G_FREE) |-> $past(all_idle));

    // R8: no activate is accepted while the activate spacing is running
    p_rrd_gap_r8: assert property (@(posedge clk) disable iff (rst)
        act_done |-> !rrd_busy);

    // R9: a running refresh window is never cut short
    p_rc_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (g_st == G_REFRESH && g_cnt != '0) |=> g_st == G_REFRESH);

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import sdg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 8,
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 7,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 2,
    parameter int T_RC      = 8,
    parameter int T_MRD     = 2,
    parameter int BURST_LEN = 4,
    parameter int T_DPL     = 2,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            addr_ap,
    output logic            err_pulse,
    output logic [2:0]      err_code,
    output logic [BA_W-1:0] err_bank
);
    logic            cke_q;
    cmd_t            op, op_b;
    err_t            g_err, code;
    err_t            bank_err [NUM_BANKS];
    logic [NUM_BANKS-1:0] idle_vec, hit;
    logic            all_idle, rrd_busy, commit, act_done;
    err_t            pick_code;
    logic [BA_W-1:0] pick_bank, first_busy, bank_sel;

    // A cycle counts only when the clock enable was high at the previous edge.
    assign op       = cke_q ? decode_cmd(cs_n, ras_n, cas_n, we_n) : C_NOP;
    assign op_b     = (g_err != E_NONE) ? C_NOP : op;
    assign all_idle = &idle_vec;
    assign commit   = (code == E_NONE);
    assign act_done = (op_b == C_ACT) && commit;

    sdg_global #(
        .CNT_W(CNT_W), .T_RC(T_RC), .T_MRD(T_MRD), .T_RRD(T_RRD)
    ) u_global (
        .clk(clk), .rst(rst), .op(op), .all_idle(all_idle),
        .act_done(act_done), .g_err(g_err), .rrd_busy(rrd_busy)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        assign hit[i] = (op_b == C_PRE && addr_ap) ||
                        (ba == BA_W'(i) && op_b inside {C_ACT, C_RD, C_WR, C_PRE});
        sdg_bank #(
            .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
            .BURST_LEN(BURST_LEN), .T_DPL(T_DPL)
        ) u_bank (
            .clk(clk), .rst(rst), .op(op_b), .hit(hit[i]), .ap(addr_ap),
            .rrd_busy(rrd_busy), .commit(commit),
            .err(bank_err[i]), .idle_now(idle_vec[i])
        );
    end

    // Walk from the top bank down so the lowest-numbered one wins.
    always_comb begin
        pick_code  = E_NONE;
        pick_bank  = '0;
        first_busy = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (bank_err[i] != E_NONE) begin
                pick_code = bank_err[i];
                pick_bank = BA_W'(i);
            end
            if (!idle_vec[i]) first_busy = BA_W'(i);
        end
        if (g_err != E_NONE) begin
            code     = g_err;
            bank_sel = (g_err == E_STATE) ? first_busy : ba;
        end else begin
            code     = pick_code;
            bank_sel = pick_bank;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q     <= 1'b0;
            err_pulse <= 1'b0;
            err_code  <= 3'd0;
            err_bank  <= '0;
        end else begin
            cke_q     <= cke;
            err_pulse <= (code != E_NONE);
            err_code  <= code;
            err_bank  <= bank_sel;
        end
    end

    // R2: a deselected cycle never leads to an error pulse
    p_cs_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_n) && !$past(rst)) |-> !err_pulse);

    // R2: a cycle following a low clock enable is never judged
    p_cke_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(cke, 2) && !$past(rst) && !$past(rst, 2)) |-> !err_pulse);

endmodule

// File: tb/sdram_cmd_guard_test.sv
module sdram_cmd_guard_test;
    localparam int T_RCD = 3, T_RAS = 7, T_RP = 3, T_RRD = 2;
    localparam int T_RC = 8, T_MRD = 2, BL = 4, T_DPL = 2;

    localparam logic [2:0] K_MRS = 3'b000, K_REF = 3'b001, K_PRE = 3'b010,
                           K_ACT = 3'b011, K_WR = 3'b100, K_RD = 3'b101,
                           K_NOP = 3'b111;

    logic clk = 1'b0, rst = 1'b1, cke = 1'b1, cs_n = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, addr_ap = 1'b0;
    logic [1:0] ba = '0;
    logic err_pulse;
    logic [2:0] err_code;
    logic [1:0] err_bank;

    int vectors = 0, miscompares = 0, cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdram_cmd_guard #(
        .NUM_BANKS(4), .CNT_W(8), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
        .T_RRD(T_RRD), .T_RC(T_RC), .T_MRD(T_MRD), .BURST_LEN(BL), .T_DPL(T_DPL)
    ) uut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr_ap(addr_ap),
        .err_pulse(err_pulse), .err_code(err_code), .err_bank(err_bank)
    );

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            miscompares++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            report();
        end
    end

    // Drive one command at a falling edge; return after the next falling edge.
    task automatic send(input logic [2:0] k, input logic [1:0] b,
                        input logic ap = 1'b0, input logic ck = 1'b1,
                        input logic desel = 1'b0);
        cs_n = desel;
        {ras_n, cas_n, we_n} = k;
        ba = b;
        addr_ap = ap;
        cke = ck;
        @(negedge clk);
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) send(K_NOP, 2'd0);
    endtask

    task automatic expect_err(input string req, input logic ep,
                              input logic [2:0] ec = 3'd0, input logic [1:0] eb = 2'd0);
        vectors++;
        if (err_pulse !== ep || (ep && (err_code !== ec || err_bank !== eb))) begin
            miscompares++;
            $display("FAIL %s: pulse/code/bank got %b/%0d/%0d expected %b/%0d/%0d",
                     req, err_pulse, err_code, err_bank, ep, ec, eb);
        end
    endtask

    task automatic reset_dut();
        rst = 1'b1;
        send(K_NOP, 2'd0);
        send(K_NOP, 2'd0);
        send(K_NOP, 2'd0);
        rst = 1'b0;
        send(K_NOP, 2'd0);
    endtask

    task automatic t_reset_r1();
        reset_dut();
        expect_err("R1 reset quiet", 1'b0);
        for (int b = 0; b < 4; b++) begin
            send(K_ACT, 2'(b));
            expect_err("R1 all banks idle", 1'b0);
            send(K_NOP, 2'd0);
        end
    endtask

    task automatic t_ignore_r2();
        reset_dut();
        send(K_ACT, 2'd0);
        nops(3);
        send(K_MRS, 2'd0, 1'b0, 1'b1, 1'b1);
        expect_err("R2 deselect ignored", 1'b0);
        send(K_NOP, 2'd0, 1'b0, 1'b0);
        send(K_MRS, 2'd0);
        expect_err("R2 cke low ignored", 1'b0);
        send(K_REF, 2'd1, 1'b0, 1'b0);
        expect_err("R2 self refresh entry judged", 1'b1, 3'd1, 2'd0);
        send(K_NOP, 2'd0);
        send(K_MRS, 2'd3);
        expect_err("R2 bank still open", 1'b1, 3'd1, 2'd0);
    endtask

    task automatic t_global_state_r3();
        reset_dut();
        send(K_ACT, 2'd2);
        send(K_NOP, 2'd0);
        send(K_REF, 2'd0);
        expect_err("R3 refresh while open", 1'b1, 3'd1, 2'd2);
        send(K_ACT, 2'd1);
        expect_err("R3 second activate ok", 1'b0);
        send(K_MRS, 2'd3);
        expect_err("R3 lowest open bank", 1'b1, 3'd1, 2'd1);
    endtask

    task automatic t_rcd_r5();
        reset_dut();
        send(K_ACT, 2'd0);
        nops(T_RCD - 2);
        send(K_RD, 2'd0);
        expect_err("R5 read before tRCD", 1'b1, 3'd2, 2'd0);
        send(K_RD, 2'd0);
        expect_err("R12 pulse lasts one cycle / R5 read at tRCD", 1'b0);
        send(K_ACT, 2'd0);
        expect_err("R4 activate open bank", 1'b1, 3'd1, 2'd0);
        send(K_NOP, 2'd0);
        expect_err("R12 no pulse after", 1'b0);
    endtask

    task automatic t_ras_rp_r6();
        reset_dut();
        send(K_ACT, 2'd1);
        nops(T_RAS - 2);
        send(K_PRE, 2'd1);
        expect_err("R6 precharge before tRAS", 1'b1, 3'd3, 2'd1);
        send(K_PRE, 2'd1);
        expect_err("R6 precharge at tRAS", 1'b0);
        send(K_ACT, 2'd1);
        expect_err("R7 activate in tRP", 1'b1, 3'd4, 2'd1);
        send(K_RD, 2'd1);
        expect_err("R7 read in tRP", 1'b1, 3'd4, 2'd1);
        send(K_ACT, 2'd1);
        expect_err("R7 activate at tRP", 1'b0);
    endtask

    task automatic t_rrd_r8();
        reset_dut();
        send(K_ACT, 2'd0);
        send(K_ACT, 2'd1);
        expect_err("R8 activate inside tRRD", 1'b1, 3'd5, 2'd1);
        send(K_ACT, 2'd1);
        expect_err("R12 rejected activate left bank idle", 1'b0);
    endtask

    task automatic t_windows_r9();
        reset_dut();
        send(K_REF, 2'd0);
        expect_err("R9 refresh from idle", 1'b0);
        nops(T_RC - 2);
        send(K_ACT, 2'd0);
        expect_err("R9 command inside tRC", 1'b1, 3'd6, 2'd0);
        send(K_ACT, 2'd2);
        expect_err("R9 command at tRC", 1'b0);
        reset_dut();
        send(K_MRS, 2'd0);
        send(K_ACT, 2'd1);
        expect_err("R9 command inside tMRD", 1'b1, 3'd7, 2'd1);
        send(K_ACT, 2'd1);
        expect_err("R9 command at tMRD", 1'b0);
    endtask

    task automatic t_autopre_r10();
        reset_dut();
        send(K_ACT, 2'd3);
        nops(T_RCD - 1);
        send(K_RD, 2'd3, 1'b1);
        expect_err("R10 read with auto-precharge", 1'b0);
        send(K_RD, 2'd3);
        expect_err("R10 read in ap burst", 1'b1, 3'd1, 2'd3);
        send(K_ACT, 2'd3);
        expect_err("R10 activate in ap burst", 1'b1, 3'd1, 2'd3);
        send(K_PRE, 2'd3);
        expect_err("R10 precharge in ap burst", 1'b1, 3'd1, 2'd3);
        nops(BL + T_RP - 5);
        send(K_ACT, 2'd3);
        expect_err("R10 still precharging", 1'b1, 3'd4, 2'd3);
        send(K_ACT, 2'd3);
        expect_err("R10 idle after burst plus tRP", 1'b0);
    endtask

    task automatic t_interrupt_r11();
        reset_dut();
        send(K_ACT, 2'd0);
        nops(T_RAS - 1);
        send(K_RD, 2'd0);
        send(K_WR, 2'd0);
        expect_err("R11 write interrupts read", 1'b0);
        send(K_RD, 2'd0);
        expect_err("R11 read interrupts write", 1'b0);
        send(K_PRE, 2'd0);
        expect_err("R11 precharge ends burst", 1'b0);
        send(K_ACT, 2'd0);
        expect_err("R11 precharging after burst", 1'b1, 3'd4, 2'd0);
    endtask

    task automatic t_recovery_r14();
        reset_dut();
        send(K_ACT, 2'd2);
        nops(T_RAS - 1);
        send(K_WR, 2'd2);
        nops(BL - 1);
        send(K_PRE, 2'd2);
        expect_err("R14 precharge in recovery", 1'b1, 3'd1, 2'd2);
        nops(T_DPL - 1);
        send(K_PRE, 2'd2);
        expect_err("R14 precharge after recovery", 1'b0);
    endtask

    task automatic t_pre_all_r13();
        reset_dut();
        send(K_ACT, 2'd1);
        send(K_NOP, 2'd0);
        send(K_ACT, 2'd3);
        send(K_PRE, 2'd0, 1'b1);
        expect_err("R13 all-bank precharge lowest bank", 1'b1, 3'd3, 2'd1);
        nops(T_RAS - 4);
        send(K_PRE, 2'd0, 1'b1);
        expect_err("R13 remaining offender", 1'b1, 3'd3, 2'd3);
        send(K_NOP, 2'd0);
        send(K_PRE, 2'd0, 1'b1);
        expect_err("R13 all-bank precharge accepted", 1'b0);
        send(K_ACT, 2'd1);
        expect_err("R13 bank 1 precharging", 1'b1, 3'd4, 2'd1);
        send(K_NOP, 2'd0);
        send(K_ACT, 2'd1);
        expect_err("R13 bank 1 idle again", 1'b0);
    endtask

    initial begin
        @(negedge clk);
        expect_err("R1 quiet in reset", 1'b0);
        t_reset_r1();
        t_ignore_r2();
        t_global_state_r3();
        t_rcd_r5();
        t_ras_rp_r6();
        t_rrd_r8();
        t_windows_r9();
        t_autopre_r10();
        t_interrupt_r11();
        t_recovery_r14();
        t_pre_all_r13();
        report();
    end
endmodule